// File: doc/BRIEF.md
# MOESI Snooping Line-State Controller

This block holds the coherence state of every line in a small snooping private cache and decides, cycle by cycle, what each local processor request and each snooped bus transaction does to that state. A local read, write or evict may produce one bus command: fill read, read-for-ownership, invalidate or write-back. A snooped read, read-for-ownership or invalidate from another cache updates the matching line. On a snoop the block also answers whether this cache must supply the data and whether it holds a copy.

Each line state is built from three attribute bits: validity, exclusiveness and ownership. An owning line (Owned or Modified) means memory is stale, so this cache must answer snooped requests for that line. Exclusive-to-Modified on a local write, and the drop of an Exclusive or Shared line to Invalid, happen with no bus traffic. The shared-line response collected from the other caches during a fill read picks Shared or Exclusive as the fill state. Tag lookup is modelled as one tracked line per index. Command outputs and snoop responses are combinational in the cycle of the request, and the state changes at the next clock edge.

Top module: `moesi_line_ctrl`

## Requirements
- R1: After reset every line reads Invalid on `lk_state`.
- R2: `lk_state` shows the state of line `cpu_idx` as three attribute bits, bit 2 owned, bit 1 exclusive, bit 0 valid: Invalid 3'b000, Shared 3'b001, Exclusive 3'b011, Owned 3'b101, Modified 3'b111. No other code ever appears.
- R3: A local read (`cpu_op`=1) to a valid line issues no bus command (`bus_cmd`=0) and keeps the state. A read to an Invalid line issues a fill read (`bus_cmd`=1) and fills Shared if `shared_in` is high in that cycle, Exclusive if it is low.
- R4: A local write (`cpu_op`=2) always leaves the line Modified. From Exclusive or Modified it issues no bus command. From Shared or Owned it issues an invalidate (`bus_cmd`=3). From Invalid it issues a read-for-ownership (`bus_cmd`=2).
- R5: A local evict (`cpu_op`=3) leaves the line Invalid. From Owned or Modified it issues a write-back (`bus_cmd`=4). From Exclusive, Shared or Invalid it issues nothing.
- R6: A snooped read (`snp_op`=1) to a valid line raises `snp_shared`. Exclusive becomes Shared, Modified becomes Owned, and Shared and Owned stay. `snp_supply` is raised when the line is Owned or Modified.
- R7: A snooped read-for-ownership (`snp_op`=2) leaves the line Invalid. `snp_supply` is raised when the line was Owned or Modified.
- R8: A snooped invalidate (`snp_op`=3) leaves the line Invalid and never raises `snp_supply`.
- R9: Requests and snoops change only the line they index. All other lines keep their state.
- R10: In a harness of four caches on one broadcast bus, the states of any line across the caches always form a legal set: either no Exclusive or Modified copy with at most one Owned copy, or exactly one Exclusive or Modified copy with all others Invalid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_op | input | 2 | Local request: 0 none, 1 read, 2 write, 3 evict |
| cpu_idx | input | IDX_W | Line addressed by the local request and by `lk_state` |
| snp_op | input | 2 | Snooped transaction: 0 none, 1 read, 2 read-for-ownership, 3 invalidate |
| snp_idx | input | IDX_W | Line addressed by the snoop |
| shared_in | input | 1 | Combined shared-line response of the other caches during this cache's fill |
| bus_cmd | output | 3 | Command issued: 0 none, 1 fill read, 2 read-for-ownership, 3 invalidate, 4 write-back |
| snp_shared | output | 1 | This cache holds a valid copy of the line named by a snooped read |
| snp_supply | output | 1 | This cache must supply data for the snooped line |
| lk_state | output | 3 | Current state of line `cpu_idx` |

## Verification
A wrong stored state shows on `lk_state` in the cycle after the edge that wrote it, and on `bus_cmd` or `snp_supply` the next time that line is requested or snooped. A state that is locally plausible but globally wrong, such as a missed downgrade on a snooped read, shows up as an illegal mix of states across the four caches on the first step that touches the line. The bench runs a reference model per cache and per line over a long pseudo-random mix of reads, writes and evicts from all caches. After each step it compares every cache's state on the addressed line, and every 50 steps it sweeps all lines to catch changes to lines that should not have been touched.

// File: rtl/moesi_pkg.sv
package moesi_pkg;

   // Line state as three attribute bits.
   typedef struct packed {
      logic own;
      logic excl;
      logic vld;
   } lstate_t;

   localparam lstate_t LS_I = 3'b000;
   localparam lstate_t LS_S = 3'b001;
   localparam lstate_t LS_E = 3'b011;
   localparam lstate_t LS_O = 3'b101;
   localparam lstate_t LS_M = 3'b111;

   typedef enum logic [1:0] {CPU_NOP, CPU_RD, CPU_WR, CPU_EVICT} cpu_op_e;
   typedef enum logic [1:0] {SNP_NOP, SNP_RD, SNP_RFO, SNP_INV} snp_op_e;
   typedef enum logic [2:0] {BUS_NONE, BUS_RD, BUS_RFO, BUS_INV, BUS_WB} bus_cmd_e;

endpackage

// File: rtl/moesi_local_fsm.sv
module moesi_local_fsm
   import moesi_pkg::*;
(
   input  lstate_t  cur_st,
   input  cpu_op_e  op,
   input  logic     shared_in,
   output lstate_t  nxt_st,
   output logic     upd,
   output bus_cmd_e cmd
);

   always_comb begin
      nxt_st = cur_st;
      upd    = 1'b0;
      cmd    = BUS_NONE;
      unique case (op)
         CPU_RD: begin
            if (!cur_st.vld) begin
               cmd    = BUS_RD;
               upd    = 1'b1;
               nxt_st = shared_in ? LS_S : LS_E;
            end
         end
         CPU_WR: begin
            upd    = 1'b1;
            nxt_st = LS_M;
            if (!cur_st.vld)
               cmd = BUS_RFO;
            else if (!cur_st.excl)
               cmd = BUS_INV;
         end
         CPU_EVICT: begin
            upd    = cur_st.vld;
            nxt_st = LS_I;
            if (cur_st.own)
               cmd = BUS_WB;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/moesi_snoop_fsm.sv
module moesi_snoop_fsm
   import moesi_pkg::*;
(
   input  lstate_t cur_st,
   input  snp_op_e op,
   output lstate_t nxt_st,
   output logic    upd,
   output logic    supply,
   output logic    shared_out
);

   always_comb begin
      nxt_st     = cur_st;
      upd        = 1'b0;
      supply     = 1'b0;
      shared_out = 1'b0;
      unique case (op)
         SNP_RD: begin
            shared_out = cur_st.vld;
            supply     = cur_st.own;
            upd        = cur_st.vld;
            // Exclusiveness is lost, ownership is kept.
            nxt_st     = '{own: cur_st.own, excl: 1'b0, vld: cur_st.vld};
         end
         SNP_RFO: begin
            supply = cur_st.own;
            upd    = cur_st.vld;
            nxt_st = LS_I;
         end
         SNP_INV: begin
            upd    = cur_st.vld;
            nxt_st = LS_I;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/moesi_line_store.sv
module moesi_line_store
   import moesi_pkg::*;
#(
   parameter int IDX_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             loc_we,
   input  logic [IDX_W-1:0] loc_idx,
   input  lstate_t          loc_st,
   input  logic             snp_we,
   input  logic [IDX_W-1:0] snp_idx,
   input  lstate_t          snp_st,
   input  logic [IDX_W-1:0] rda_idx,
   output lstate_t          rda_st,
   input  logic [IDX_W-1:0] rdb_idx,
   output lstate_t          rdb_st
);

   localparam int LINES = 1 << IDX_W;

   lstate_t line_v [LINES];

   for (genvar g = 0; g < LINES; g++) begin : g_line
      lstate_t st_q;
      // A snoop to the same line wins over the local update.
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            st_q <= LS_I;
         else if (snp_we && (snp_idx == IDX_W'(g)))
            st_q <= snp_st;
         else if (loc_we && (loc_idx == IDX_W'(g)))
            st_q <= loc_st;
      end
      assign line_v[g] = st_q;
   end

   assign rda_st = line_v[rda_idx];
   assign rdb_st = line_v[rdb_idx];

endmodule

// File: rtl/moesi_line_ctrl.sv
module moesi_line_ctrl
   import moesi_pkg::*;
#(
   parameter int IDX_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       cpu_op,
   input  logic [IDX_W-1:0] cpu_idx,
   input  logic [1:0]       snp_op,
   input  logic [IDX_W-1:0] snp_idx,
   input  logic             shared_in,
   output logic [2:0]       bus_cmd,
   output logic             snp_shared,
   output logic             snp_supply,
   output logic [2:0]       lk_state
);

   initial begin : chk_params
      assert (IDX_W >= 1 && IDX_W <= 10)
         else $error("moesi_line_ctrl: IDX_W must be 1..10");
   end

   lstate_t  loc_cur, loc_nxt, snp_cur, snp_nxt;
   logic     loc_upd, snp_upd;
   bus_cmd_e loc_cmd;

   moesi_line_store #(.IDX_W(IDX_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .loc_we  (loc_upd),
      .loc_idx (cpu_idx),
      .loc_st  (loc_nxt),
      .snp_we  (snp_upd),
      .snp_idx (snp_idx),
      .snp_st  (snp_nxt),
      .rda_idx (cpu_idx),
      .rda_st  (loc_cur),
      .rdb_idx (snp_idx),
      .rdb_st  (snp_cur)
   );

   moesi_local_fsm u_local (
      .cur_st    (loc_cur),
      .op        (cpu_op_e'(cpu_op)),
      .shared_in (shared_in),
      .nxt_st    (loc_nxt),
      .upd       (loc_upd),
      .cmd       (loc_cmd)
   );

   moesi_snoop_fsm u_snoop (
      .cur_st     (snp_cur),
      .op         (snp_op_e'(snp_op)),
      .nxt_st     (snp_nxt),
      .upd        (snp_upd),
      .supply     (snp_supply),
      .shared_out (snp_shared)
   );

   assign bus_cmd  = loc_cmd;
   assign lk_state = loc_cur;

endmodule

// File: rtl/moesi_line_chk.sv
module moesi_line_chk #(
   parameter int IDX_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       cpu_op,
   input logic [IDX_W-1:0] cpu_idx,
   input logic [1:0]       snp_op,
   input logic [IDX_W-1:0] snp_idx,
   input logic             shared_in,
   input logic [2:0]       bus_cmd,
   input logic             snp_shared,
   input logic             snp_supply,
   input logic [2:0]       lk_state
);

   assert_legal_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
      lk_state inside {3'b000, 3'b001, 3'b011, 3'b101, 3'b111});

   assert_miss_fill_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_op == 2'd1 && !lk_state[0]) |-> bus_cmd == 3'd1);

   assert_fill_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_op == 2'd1 && !lk_state[0] && snp_op == 2'd0)
      |=> (!$stable(cpu_idx) || lk_state == ($past(shared_in) ? 3'b001 : 3'b011)));

   assert_write_mod_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_op == 2'd2 && snp_op == 2'd0) |=> (!$stable(cpu_idx) || lk_state == 3'b111));

   assert_silent_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_op == 2'd2 && lk_state[1]) |-> bus_cmd == 3'd0);

   assert_owner_wb_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_op == 2'd3 && lk_state[2]) |-> bus_cmd == 3'd4);

   assert_supply_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
      snp_supply |-> (snp_op == 2'd1 || snp_op == 2'd2));

   assert_shared_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
      snp_shared |-> snp_op == 2'd1);

   assert_rfo_supply_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_op == 2'd2 && snp_idx == cpu_idx && lk_state[2]) |-> snp_supply);

   assert_inv_nosupply_R8: assert property (@(posedge clk) disable iff (!rst_n)
      snp_op == 2'd3 |-> !snp_supply);

endmodule

bind moesi_line_ctrl moesi_line_chk #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/moesi_line_ctrl_tb_top.sv
`timescale 1ns/1ps
module moesi_line_ctrl_tb_top;

   localparam int IW = 2;
   localparam int NL = 1 << IW;
   localparam int NC = 4;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst_n;
   logic [1:0]    cpu_op  [NC];
   logic [IW-1:0] idx;
   logic [1:0]    snp_op  [NC];
   logic          shared_in [NC];
   logic [2:0]    bus_cmd [NC];
   logic          snp_shared [NC];
   logic          snp_supply [NC];
   logic [2:0]    lk [NC];
   int            act;
   logic [1:0]    bus_snp;

   for (genvar c = 0; c < NC; c++) begin : g_cache
      moesi_line_ctrl #(.IDX_W(IW)) dut_i (
         .clk        (clk),
         .rst_n      (rst_n),
         .cpu_op     (cpu_op[c]),
         .cpu_idx    (idx),
         .snp_op     (snp_op[c]),
         .snp_idx    (idx),
         .shared_in  (shared_in[c]),
         .bus_cmd    (bus_cmd[c]),
         .snp_shared (snp_shared[c]),
         .snp_supply (snp_supply[c]),
         .lk_state   (lk[c])
      );
   end

   // Broadcast bus model: acting cache's command is snooped by the rest.
   always_comb begin
      case (bus_cmd[act])
         3'd1:    bus_snp = 2'd1;
         3'd2:    bus_snp = 2'd2;
         3'd3:    bus_snp = 2'd3;
         default: bus_snp = 2'd0;
      endcase
   end

   always_comb begin
      for (int c = 0; c < NC; c++)
         snp_op[c] = (c == act) ? 2'd0 : bus_snp;
   end

   always_comb begin
      for (int c = 0; c < NC; c++) begin
         shared_in[c] = 1'b0;
         for (int k = 0; k < NC; k++)
            if (k != c) shared_in[c] = shared_in[c] | snp_shared[k];
      end
   end

   // Reference model
   logic [2:0] rs [NC][NL];
   int n_chk = 0;
   int n_fail = 0;

   task automatic chk(string rq, string what, int got, int exp);
      n_chk++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d", rq, what, got, exp);
      end
   endtask

   function automatic logic [2:0] f_cmd(logic [2:0] st, int op);
      case (op)
         1: return (st == 3'b000) ? 3'd1 : 3'd0;
         2: return (st == 3'b000) ? 3'd2 : ((st == 3'b001 || st == 3'b101) ? 3'd3 : 3'd0);
         3: return (st == 3'b101 || st == 3'b111) ? 3'd4 : 3'd0;
         default: return 3'd0;
      endcase
   endfunction

   function automatic logic [2:0] f_local(logic [2:0] st, int op, logic sh);
      case (op)
         1: return (st == 3'b000) ? (sh ? 3'b001 : 3'b011) : st;
         2: return 3'b111;
         3: return 3'b000;
         default: return st;
      endcase
   endfunction

   function automatic logic [2:0] f_snoop(logic [2:0] st, int sop);
      case (sop)
         1: case (st)
               3'b011: return 3'b001;
               3'b111: return 3'b101;
               default: return st;
            endcase
         2, 3: return 3'b000;
         default: return st;
      endcase
   endfunction

   function automatic string op_tag(int op);
      return (op == 1) ? "R3" : (op == 2) ? "R4" : (op == 3) ? "R5" : "R9";
   endfunction

   function automatic string snp_tag(int sop);
      return (sop == 1) ? "R6" : (sop == 2) ? "R7" : (sop == 3) ? "R8" : "R9";
   endfunction

   task automatic chk_legal(int ln);
      int ns = 0, ne = 0, no = 0, nm = 0;
      bit ok;
      for (int k = 0; k < NC; k++) begin
         case (lk[k])
            3'b001: ns++;
            3'b011: ne++;
            3'b101: no++;
            3'b111: nm++;
            default: ;
         endcase
      end
      ok = ((ne + nm) == 0 && no <= 1) || ((ne + nm) == 1 && no == 0 && ns == 0);
      chk("R10", $sformatf("legal state mix on line %0d", ln), int'(ok), 1);
   endtask

   task automatic step(int c, int op, int ln);
      logic [2:0] ecmd;
      int sop;
      logic esh;
      @(negedge clk);
      act = c;
      idx = IW'(ln);
      for (int k = 0; k < NC; k++) cpu_op[k] = (k == c) ? 2'(op) : 2'd0;
      #1;
      ecmd = f_cmd(rs[c][ln], op);
      chk(op_tag(op), $sformatf("bus_cmd cache %0d line %0d", c, ln), int'(bus_cmd[c]), int'(ecmd));
      sop = (ecmd >= 3'd1 && ecmd <= 3'd3) ? int'(ecmd) : 0;
      esh = 1'b0;
      for (int k = 0; k < NC; k++) begin
         if (k != c) begin
            chk(snp_tag(sop), $sformatf("snp_supply cache %0d", k), int'(snp_supply[k]),
                int'((sop == 1 || sop == 2) && rs[k][ln][2]));
            if (sop == 1 && rs[k][ln][0]) esh = 1'b1;
         end
      end
      rs[c][ln] = f_local(rs[c][ln], op, esh);
      for (int k = 0; k < NC; k++)
         if (k != c) rs[k][ln] = f_snoop(rs[k][ln], sop);
      @(posedge clk);
      #1;
      for (int k = 0; k < NC; k++) cpu_op[k] = 2'd0;
      for (int k = 0; k < NC; k++)
         chk((k == c) ? op_tag(op) : snp_tag(sop), $sformatf("state cache %0d line %0d", k, ln),
             int'(lk[k]), int'(rs[k][ln]));
      chk_legal(ln);
   endtask

   // Untouched lines keep their state (R9).
   task automatic sweep(string rq);
      @(negedge clk);
      for (int k = 0; k < NC; k++) cpu_op[k] = 2'd0;
      for (int ln = 0; ln < NL; ln++) begin
         idx = IW'(ln);
         #1;
         for (int k = 0; k < NC; k++)
            chk(rq, $sformatf("sweep cache %0d line %0d", k, ln), int'(lk[k]), int'(rs[k][ln]));
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin : watchdog
      #(4 * 150000);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin : main
      int unsigned lcg;
      act = 0;
      idx = '0;
      for (int k = 0; k < NC; k++) cpu_op[k] = 2'd0;
      for (int k = 0; k < NC; k++)
         for (int ln = 0; ln < NL; ln++) rs[k][ln] = 3'b000;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      sweep("R1");

      // Directed walk through all five codes (R2)
      step(0, 1, 0);
      chk("R2", "Exclusive code", int'(lk[0]), 3);
      step(0, 2, 0);
      chk("R2", "Modified code", int'(lk[0]), 7);
      step(1, 1, 0);
      chk("R2", "Owned code", int'(lk[0]), 5);
      chk("R2", "Shared code", int'(lk[1]), 1);
      step(2, 1, 0);
      step(1, 2, 0);
      chk("R2", "Invalid code", int'(lk[0]), 0);
      step(1, 3, 0);
      step(3, 1, 1);
      step(3, 3, 1);
      step(2, 2, 2);
      step(0, 2, 2);
      sweep("R9");

      lcg = 32'h1234_5678;
      for (int s = 0; s < 4000; s++) begin
         int c, op, ln;
         lcg = lcg * 32'd1103515245 + 32'd12345;
         c  = int'((lcg >> 16) % NC);
         op = int'((lcg >> 20) % 4);
         ln = int'((lcg >> 24) % NL);
         step(c, op, ln);
         if ((s % 50) == 49) sweep("R9");
      end
      sweep("R9");
      finish_run();
   end

endmodule